// File: doc/BRIEF.md
# Hysteretic Burst-Mode Switching Gate

This block decides, cycle by cycle, whether a resonant power stage may switch. It takes a digital frequency command from the feedback path. It compares that command against two burst thresholds, a stop level and a lower start level. Both levels are fixed fractions of a programmable maximum-frequency code. When the command climbs past the stop level, switching pauses. It resumes only after the command has dropped below the start level. This gives a hysteretic burst pattern at light load.

Three ratio sets for the two thresholds are available. The set is picked by a two-bit selection input. That input is only observed during a sensing window of a parameterised number of clock cycles, which begins when the supply-good signal is asserted. The value seen in the last window cycle is held until the supply drops. The maximum-frequency code is not latched and keeps feeding the threshold arithmetic continuously.

Top module: `burst_gate`

## Requirements
- R1: While switching is enabled, a command strictly greater than the stop threshold disables it. A command equal to the stop threshold keeps it enabled.
- R2: While switching is disabled, it re-enables only when the command is strictly less than the start threshold. A command between the two thresholds, or equal to the start threshold, leaves the enable unchanged.
- R3: Each threshold is floor(fmax * k / 256). Selection code 2'b00 gives stop k=224 and start k=192. Code 2'b01 gives stop k=192 and start k=160. Code 2'b10 gives stop k=160 and start k=128.
- R4: Selection code 2'b11 behaves exactly like code 2'b10, which is the set with the lowest thresholds.
- R5: The selection input is sampled during each of the WIN_CYC cycles that follow the assertion of supply-good. The value from the last window cycle is kept, and later changes of the selection input have no effect.
- R6: After the window, the thresholds follow changes of the fmax input on every cycle.
- R7: The enable stays low through the whole sensing window. Its earliest possible rise is the clock edge just after the window ends, and only if the command is below the start threshold.
- R8: When supply-good is low, the enable is low after the next clock edge and the latched selection is cleared. The sensing window restarts when supply-good returns.
- R9: Asynchronous active-low reset forces the enable low at once and restarts the sensing window.
- R10: The enable is a registered output and responds one clock edge after the input condition is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply-good indication, synchronous to clk_i |
| freq_cmd_i | input | W | Commanded switching frequency code |
| fmax_i | input | W | Programmed maximum frequency code |
| ratio_sel_i | input | 2 | Burst threshold ratio selection |
| sw_en_o | output | 1 | Switching enable for the power stage |

## Verification
The hardest behaviour to reach from the ports is which selection value ends up latched. The selection input is only live for the window, so the bench toggles it through several codes during the window and puts the intended code on it only in the last window cycle. After the window it also changes the input on purpose. It then tells the latched set apart by stepping the command into levels where the three ratio sets would give different enable results. The same method exposes the mapping of code 2'b11. The first cycle after the window is checked with the command already below the start level, which shows that the earliest release happens at exactly that edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    RSET_WIDE = 2'b00,
    RSET_MID  = 2'b01,
    RSET_LOW  = 2'b10,
    RSET_ALT  = 2'b11
  } rset_e;

  typedef struct packed {
    logic [7:0] stop_k;
    logic [7:0] start_k;
  } ratio_pair_t;

  // Q0.8 fractions of fmax; unused code folds onto the lowest set
  function automatic ratio_pair_t ratio_of(rset_e sel);
    ratio_pair_t r;
    unique case (sel)
      RSET_WIDE: r = '{stop_k: 8'd224, start_k: 8'd192};
      RSET_MID:  r = '{stop_k: 8'd192, start_k: 8'd160};
      default:   r = '{stop_k: 8'd160, start_k: 8'd128};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/burst_sense_win.sv
module burst_sense_win
  import burst_pkg::*;
#(
  parameter int unsigned WIN_CYC = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic [1:0] ratio_sel_i,
  output rset_e      ratio_o,
  output logic       done_o
);

  localparam int unsigned CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  rset_e         ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ratio_q <= RSET_WIDE;
    end else if (!supply_ok_i) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ratio_q <= RSET_WIDE;
    end else if (!done_q) begin
      ratio_q <= rset_e'(ratio_sel_i);
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ratio_o = ratio_q;
  assign done_o  = done_q;

endmodule

// File: rtl/burst_thresh.sv
module burst_thresh
  import burst_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] fmax_i,
  input  rset_e        ratio_i,
  output logic [W-1:0] stop_thr_o,
  output logic [W-1:0] start_thr_o
);

  localparam int unsigned PW = W + 8;

  ratio_pair_t     pair;
  logic [7:0]      k   [2];
  logic [W-1:0]    thr [2];

  assign pair = ratio_of(ratio_i);
  assign k[0] = pair.stop_k;
  assign k[1] = pair.start_k;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    logic [PW-1:0] prod;
    assign prod   = PW'(fmax_i) * PW'(k[g]);
    assign thr[g] = W'(prod >> 8);
  end

  assign stop_thr_o  = thr[0];
  assign start_thr_o = thr[1];

endmodule

// File: rtl/burst_hyst.sv
module burst_hyst #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         supply_ok_i,
  input  logic         armed_i,
  input  logic [W-1:0] cmd_i,
  input  logic [W-1:0] stop_thr_i,
  input  logic [W-1:0] start_thr_i,
  output logic         en_o
);

  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= 1'b0;
    else if (!supply_ok_i || !armed_i)   en_q <= 1'b0;
    else if (en_q && cmd_i > stop_thr_i) en_q <= 1'b0;
    else if (!en_q && cmd_i < start_thr_i) en_q <= 1'b1;
  end

  assign en_o = en_q;

endmodule

// File: rtl/burst_gate.sv
module burst_gate
  import burst_pkg::*;
#(
  parameter int unsigned W       = 12,
  parameter int unsigned WIN_CYC = 25_000_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         supply_ok_i,
  input  logic [W-1:0] freq_cmd_i,
  input  logic [W-1:0] fmax_i,
  input  logic [1:0]   ratio_sel_i,
  output logic         sw_en_o
);

  rset_e        ratio_q;
  logic         win_done;
  logic [W-1:0] stop_thr;
  logic [W-1:0] start_thr;

  burst_sense_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .ratio_sel_i (ratio_sel_i),
    .ratio_o     (ratio_q),
    .done_o      (win_done)
  );

  burst_thresh #(.W(W)) u_thr (
    .fmax_i      (fmax_i),
    .ratio_i     (ratio_q),
    .stop_thr_o  (stop_thr),
    .start_thr_o (start_thr)
  );

  burst_hyst #(.W(W)) u_hyst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .armed_i     (win_done),
    .cmd_i       (freq_cmd_i),
    .stop_thr_i  (stop_thr),
    .start_thr_i (start_thr),
    .en_o        (sw_en_o)
  );

endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         supply_ok_i,
  input logic [W-1:0] freq_cmd_i,
  input logic         sw_en_o,
  input logic         win_done,
  input logic [1:0]   ratio_q,
  input logic [W-1:0] stop_thr,
  input logic [W-1:0] start_thr
);

  // R8
  supply_drop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !sw_en_o);

  // R7
  window_hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done |-> !sw_en_o);

  // R5
  ratio_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done && supply_ok_i) |=> (!win_done || $stable(ratio_q)));

  // R2
  resume_below_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> $past(freq_cmd_i < start_thr));

  // R1
  stop_above_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> $past(!supply_ok_i || freq_cmd_i > stop_thr));

endmodule

bind burst_gate burst_gate_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .freq_cmd_i  (freq_cmd_i),
  .sw_en_o     (sw_en_o),
  .win_done    (win_done),
  .ratio_q     (ratio_q),
  .stop_thr    (stop_thr),
  .start_thr   (start_thr)
);

// File: tb/burst_gate_bench.sv
module burst_gate_bench;

  localparam int unsigned W   = 12;
  localparam int unsigned WIN = 16;
  localparam int unsigned NV  = 15;

  typedef struct packed {
    logic [W-1:0] cmd;
    logic [W-1:0] fmax;
    logic         en;
  } vec_t;

  // set 00 latched: fmax 1000 -> stop 875 start 750; 2000 -> 1750/1500; 500 -> 437/375
  localparam vec_t VEC [NV] = '{
    '{12'd800,  12'd1000, 1'b0},
    '{12'd750,  12'd1000, 1'b0},
    '{12'd749,  12'd1000, 1'b1},
    '{12'd870,  12'd1000, 1'b1},
    '{12'd875,  12'd1000, 1'b1},
    '{12'd876,  12'd1000, 1'b0},
    '{12'd800,  12'd1000, 1'b0},
    '{12'd700,  12'd1000, 1'b1},
    '{12'd1600, 12'd2000, 1'b1},
    '{12'd1751, 12'd2000, 1'b0},
    '{12'd1600, 12'd2000, 1'b0},
    '{12'd1499, 12'd2000, 1'b1},
    '{12'd438,  12'd500,  1'b0},
    '{12'd400,  12'd500,  1'b0},
    '{12'd374,  12'd500,  1'b1}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         supply_ok_i;
  logic [W-1:0] freq_cmd_i;
  logic [W-1:0] fmax_i;
  logic [1:0]   ratio_sel_i;
  logic         sw_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit fin    = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_gate #(.W(W), .WIN_CYC(WIN)) u_burst_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .freq_cmd_i  (freq_cmd_i),
    .fmax_i      (fmax_i),
    .ratio_sel_i (ratio_sel_i),
    .sw_en_o     (sw_en_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_en_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // raise supply, wiggle selection, present final code only in the last window cycle
  task automatic power_up(logic [1:0] final_sel, logic [W-1:0] cmd);
    freq_cmd_i  = cmd;
    supply_ok_i = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      ratio_sel_i = (i == WIN - 1) ? final_sel : 2'(i % 3);
      step();
      chk("R7", sw_en_o, 1'b0);
    end
  endtask

  task automatic drive(logic [W-1:0] cmd, logic exp, string req);
    freq_cmd_i = cmd;
    step();
    chk(req, sw_en_o, exp);
  endtask

  initial begin
    #(20 * 5000);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni      = 1'b0;
    supply_ok_i = 1'b0;
    freq_cmd_i  = '0;
    fmax_i      = 12'd1000;
    ratio_sel_i = 2'b00;
    step();
    step();
    chk("R9", sw_en_o, 1'b0);
    rst_ni = 1'b1;

    // supply not good: low command must not enable (R8)
    step();
    step();
    chk("R8", sw_en_o, 1'b0);

    // table walk, set 00 (R1 R2 R3 R6 R10)
    power_up(2'b00, 12'd800);
    for (int v = 0; v < NV; v++) begin
      freq_cmd_i = VEC[v].cmd;
      fmax_i     = VEC[v].fmax;
      step();
      chk((v >= 8) ? "R6" : ((v == 4 || v == 5) ? "R1" : "R2"), sw_en_o, VEC[v].en);
    end

    // supply drop clears enable at next edge (R8)
    fmax_i      = 12'd1000;
    supply_ok_i = 1'b0;
    step();
    chk("R8", sw_en_o, 1'b0);

    // latch set 10: stop 625 start 500 (R5)
    power_up(2'b10, 12'd550);
    drive(12'd550, 1'b0, "R5");
    drive(12'd499, 1'b1, "R3");
    ratio_sel_i = 2'b00;
    drive(12'd600, 1'b1, "R5");
    drive(12'd700, 1'b0, "R5");

    // latch set 01: stop 750 start 625, earliest release (R7)
    supply_ok_i = 1'b0;
    step();
    chk("R8", sw_en_o, 1'b0);
    power_up(2'b01, 12'd0);
    drive(12'd0,   1'b1, "R7");
    drive(12'd750, 1'b1, "R3");
    drive(12'd751, 1'b0, "R3");
    drive(12'd625, 1'b0, "R3");
    drive(12'd624, 1'b1, "R3");

    // code 11 behaves as set 10 (R4)
    supply_ok_i = 1'b0;
    step();
    power_up(2'b11, 12'd550);
    drive(12'd550, 1'b0, "R4");
    drive(12'd499, 1'b1, "R4");
    drive(12'd626, 1'b0, "R4");

    // async reset mid-run restarts the window (R9)
    drive(12'd0, 1'b1, "R10");
    #2 rst_ni = 1'b0;
    #1 chk("R9", sw_en_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    freq_cmd_i = 12'd0;
    for (int i = 0; i < WIN; i++) begin
      step();
      chk("R9", sw_en_o, 1'b0);
    end
    drive(12'd0, 1'b1, "R9");

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule